// File: doc/BRIEF.md
# Interrupt presentation priority controller

This block is the per-processor end of an interrupt fabric. It holds at most one pending interrupt and the processor's current priority threshold, and it drives one interrupt line into the processor. Source units offer interrupts as a source number with an 8-bit priority. In the same cycle the block takes each offer or bounces it back. A smaller priority value is more favoured, and the value 0xFF stands for "none" or least favoured.

The processor side has five operations. It can read the presentation word (poll). It can take the pending interrupt with an acknowledging read. It can write a new threshold, write an inter-processor request level, or write an end-of-interrupt word. An inter-processor request is presented under the fixed source number 2 and has no owning source. When a held source interrupt is displaced or dropped, the block sends a reject for it. When the block becomes empty after a threshold change or an end-of-interrupt, it asks the sources to resend. Reject, end-of-interrupt and resend messages leave as single-cycle pulses.

The presentation word has the threshold in bits 31:24 and the pending source number in bits 23:0. A pending number of zero means that nothing is pending.

Top module: `intr_present_ctrl`

## Requirements
- R1: After reset the presentation word is 0 and the request level `ipi_level` is 0xFF. `irq_out` is low and no reject, end-of-interrupt or resend pulse is active. The pending priority is 0xFF.
- R2: An offer with priority P is taken (`dlv_accept`=1) in the same cycle only if all of these hold: no processor operation strobe is high in that cycle, P is strictly less than the threshold, and either nothing is pending or P is strictly less than the pending priority. Every other offer gets `dlv_reject`=1. Exactly one of the two responses is high whenever `dlv_valid` is high.
- R3: A taken offer becomes the pending interrupt at the next edge: the pending number is the offered number and the pending priority is P. If a source-owned interrupt was pending, one cycle after the offer a reject pulse carries that interrupt's number. A displaced inter-processor interrupt produces no reject.
- R4: `pres_word` always shows {threshold, pending number} (poll). An acknowledging read (`ack_rd`) sees the current word in that cycle. At the next edge the threshold becomes the pending priority, the pending number becomes 0 and the pending priority becomes 0xFF, with no reject.
- R5: A threshold write C that is strictly more favoured than the old threshold stores C. If something is pending and C is less than or equal to the pending priority, the pending number is cleared, the pending priority becomes 0xFF, and a source-owned interrupt is rejected one cycle later.
- R6: A threshold write C that is greater than or equal to the old threshold, with nothing pending, stores C and pulses `resend_pulse` one cycle later. If `ipi_level` < C, the inter-processor interrupt (number 2, priority `ipi_level`) also becomes pending.
- R7: A request-level write M stores M in `ipi_level`. If M is less than the threshold and either nothing is pending or M is strictly less than the pending priority, the block rejects any pending source-owned interrupt. Number 2 with priority M then becomes pending.
- R8: An end-of-interrupt write W sets the threshold to W[31:24]. One cycle later it pulses `eoi_valid` with `eoi_num`=W[23:0]. If nothing is pending, it also triggers the resend of R6, using the new threshold.
- R9: When several operation strobes are high together, only one is performed. The order is `ack_rd` first, then `eoi_wr`, then `thr_wr`, then `ipi_wr`.
- R10: `irq_out` is high exactly when the pending number is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dlv_valid | input | 1 | Source offers an interrupt |
| dlv_num | input | 24 | Offered source number |
| dlv_prio | input | 8 | Offered priority |
| dlv_accept | output | 1 | Offer taken (same cycle) |
| dlv_reject | output | 1 | Offer bounced (same cycle) |
| ack_rd | input | 1 | Acknowledging read strobe |
| thr_wr | input | 1 | Threshold write strobe |
| thr_wdata | input | 8 | New threshold |
| ipi_wr | input | 1 | Request-level write strobe |
| ipi_wdata | input | 8 | New request level |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| eoi_wdata | input | 32 | End-of-interrupt word |
| pres_word | output | 32 | Presentation word {threshold, pending number} |
| ipi_level | output | 8 | Stored request level |
| irq_out | output | 1 | Interrupt line to the processor |
| rej_valid | output | 1 | Reject pulse to sources |
| rej_num | output | 24 | Rejected source number |
| eoi_valid | output | 1 | End-of-interrupt pulse to sources |
| eoi_num | output | 24 | End-of-interrupt source number |
| resend_pulse | output | 1 | Resend request to sources |

## Verification
The offer response and the word seen by an acknowledging read are combinational, so they are due in the cycle of the stimulus. The bench samples them 1 ns after it drives the inputs on the falling edge. The presentation word, `ipi_level`, `irq_out` and the three message pulses change at the rising edge that follows the stimulus. The bench compares them 2 ns after that edge, before it drives the next stimulus. A bench-side model advances once per cycle, so each expected value belongs to exactly one edge. Directed sequences cover displacement with and without a reject, clearing on a threshold write, and resend with and without inter-processor presentation. Seeded random traffic with narrow priority ranges then mixes concurrent strobes and offers.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
   typedef enum logic [2:0] {
      OP_NONE = 3'd0,
      OP_ACK  = 3'd1,
      OP_EOI  = 3'd2,
      OP_THR  = 3'd3,
      OP_IPI  = 3'd4
   } op_e;
endpackage

// File: rtl/ipc_op_sel.sv
module ipc_op_sel (
   input  logic          ack_rd,
   input  logic          eoi_wr,
   input  logic          thr_wr,
   input  logic          ipi_wr,
   output ipc_pkg::op_e  op
);
   always_comb begin
      if (ack_rd)      op = ipc_pkg::OP_ACK;
      else if (eoi_wr) op = ipc_pkg::OP_EOI;
      else if (thr_wr) op = ipc_pkg::OP_THR;
      else if (ipi_wr) op = ipc_pkg::OP_IPI;
      else             op = ipc_pkg::OP_NONE;
   end
endmodule

// File: rtl/ipc_dlv_arb.sv
module ipc_dlv_arb #(
   parameter int PRIO_W = 8
) (
   input  logic              valid,
   input  logic              blocked,
   input  logic [PRIO_W-1:0] prio,
   input  logic [PRIO_W-1:0] thr,
   input  logic              busy,
   input  logic [PRIO_W-1:0] pend_prio,
   output logic              accept,
   output logic              reject
);
   logic wins;
   always_comb begin
      wins   = (prio < thr) && (!busy || (prio < pend_prio));
      accept = valid && !blocked && wins;
      reject = valid && !accept;
   end
endmodule

// File: rtl/ipc_ipi_eval.sv
module ipc_ipi_eval #(
   parameter int PRIO_W = 8
) (
   input  logic [PRIO_W-1:0] level,
   input  logic [PRIO_W-1:0] thr,
   input  logic              busy,
   input  logic [PRIO_W-1:0] pend_prio,
   output logic              take
);
   assign take = (level < thr) && (!busy || (level < pend_prio));
endmodule

// File: rtl/ipc_pulse_reg.sv
module ipc_pulse_reg #(
   parameter int W   = 8,
   parameter bit REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= d;
         end
      end else begin : g_pass
         assign q = d;
      end
   endgenerate
endmodule

// File: rtl/intr_present_ctrl.sv
module intr_present_ctrl #(
   parameter int NUM_W   = 24,
   parameter int PRIO_W  = 8,
   parameter int IPI_NUM = 2,
   parameter bit MSG_REG = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    dlv_valid,
   input  logic [NUM_W-1:0]        dlv_num,
   input  logic [PRIO_W-1:0]       dlv_prio,
   output logic                    dlv_accept,
   output logic                    dlv_reject,
   input  logic                    ack_rd,
   input  logic                    thr_wr,
   input  logic [PRIO_W-1:0]       thr_wdata,
   input  logic                    ipi_wr,
   input  logic [PRIO_W-1:0]       ipi_wdata,
   input  logic                    eoi_wr,
   input  logic [PRIO_W+NUM_W-1:0] eoi_wdata,
   output logic [PRIO_W+NUM_W-1:0] pres_word,
   output logic [PRIO_W-1:0]       ipi_level,
   output logic                    irq_out,
   output logic                    rej_valid,
   output logic [NUM_W-1:0]        rej_num,
   output logic                    eoi_valid,
   output logic [NUM_W-1:0]        eoi_num,
   output logic                    resend_pulse
);
   localparam int XW    = PRIO_W + NUM_W;
   localparam int MSG_W = 2 * NUM_W + 3;
   localparam logic [PRIO_W-1:0] PRIO_NONE = {PRIO_W{1'b1}};
   localparam logic [NUM_W-1:0]  IPI_ID    = NUM_W'(IPI_NUM);

   generate
      if (PRIO_W < 2) begin : g_bad_prio
         $error("PRIO_W must be at least 2");
      end
      if (NUM_W < 2) begin : g_bad_num
         $error("NUM_W must be at least 2");
      end
      if (IPI_NUM <= 0 || IPI_NUM >= (1 << (NUM_W > 30 ? 30 : NUM_W))) begin : g_bad_ipi
         $error("IPI_NUM must be nonzero and fit in NUM_W bits");
      end
   endgenerate

   logic [PRIO_W-1:0] thr_q, pend_q, lvl_q;
   logic [NUM_W-1:0]  xisr_q;
   logic              own_q;
   logic [PRIO_W-1:0] thr_n, pend_n, lvl_n;
   logic [NUM_W-1:0]  xisr_n;
   logic              own_n;
   logic              rej_v_n, eoi_v_n, rs_n;
   logic [NUM_W-1:0]  rej_num_n;
   logic              busy;
   ipc_pkg::op_e      op;
   logic [PRIO_W-1:0] ipi_thr, ipi_lvl;
   logic              ipi_take;
   logic [PRIO_W-1:0] eoi_thr;

   assign busy    = (xisr_q != '0);
   assign eoi_thr = eoi_wdata[XW-1:NUM_W];

   ipc_op_sel u_sel (
      .ack_rd (ack_rd), .eoi_wr (eoi_wr), .thr_wr (thr_wr), .ipi_wr (ipi_wr), .op (op)
   );

   ipc_dlv_arb #(.PRIO_W(PRIO_W)) u_arb (
      .valid     (dlv_valid),
      .blocked   (op != ipc_pkg::OP_NONE),
      .prio      (dlv_prio),
      .thr       (thr_q),
      .busy      (busy),
      .pend_prio (pend_q),
      .accept    (dlv_accept),
      .reject    (dlv_reject)
   );

   // The threshold and level compared depend on the operation being performed
   always_comb begin
      ipi_thr = thr_q;
      ipi_lvl = lvl_q;
      case (op)
         ipc_pkg::OP_EOI: ipi_thr = eoi_thr;
         ipc_pkg::OP_THR: ipi_thr = thr_wdata;
         ipc_pkg::OP_IPI: ipi_lvl = ipi_wdata;
         default: ;
      endcase
   end

   ipc_ipi_eval #(.PRIO_W(PRIO_W)) u_ipi (
      .level (ipi_lvl), .thr (ipi_thr), .busy (busy), .pend_prio (pend_q), .take (ipi_take)
   );

   always_comb begin
      thr_n     = thr_q;
      pend_n    = pend_q;
      lvl_n     = lvl_q;
      xisr_n    = xisr_q;
      own_n     = own_q;
      rej_v_n   = 1'b0;
      rej_num_n = xisr_q;
      eoi_v_n   = 1'b0;
      rs_n      = 1'b0;
      case (op)
         ipc_pkg::OP_ACK: begin
            thr_n  = pend_q;
            xisr_n = '0;
            pend_n = PRIO_NONE;
            own_n  = 1'b0;
         end
         ipc_pkg::OP_EOI: begin
            thr_n   = eoi_thr;
            eoi_v_n = 1'b1;
            if (!busy) begin
               rs_n = 1'b1;
               if (ipi_take) begin
                  xisr_n = IPI_ID;
                  pend_n = lvl_q;
                  own_n  = 1'b0;
               end
            end
         end
         ipc_pkg::OP_THR: begin
            thr_n = thr_wdata;
            if (thr_wdata < thr_q) begin
               if (busy && (thr_wdata <= pend_q)) begin
                  xisr_n  = '0;
                  pend_n  = PRIO_NONE;
                  own_n   = 1'b0;
                  rej_v_n = own_q;
               end
            end else if (!busy) begin
               rs_n = 1'b1;
               if (ipi_take) begin
                  xisr_n = IPI_ID;
                  pend_n = lvl_q;
                  own_n  = 1'b0;
               end
            end
         end
         ipc_pkg::OP_IPI: begin
            lvl_n = ipi_wdata;
            if (ipi_take) begin
               rej_v_n = busy && own_q;
               xisr_n  = IPI_ID;
               pend_n  = ipi_wdata;
               own_n   = 1'b0;
            end
         end
         default: begin
            if (dlv_accept) begin
               rej_v_n = busy && own_q;
               xisr_n  = dlv_num;
               pend_n  = dlv_prio;
               own_n   = 1'b1;
            end
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         thr_q  <= '0;
         pend_q <= PRIO_NONE;
         lvl_q  <= PRIO_NONE;
         xisr_q <= '0;
         own_q  <= 1'b0;
      end else begin
         thr_q  <= thr_n;
         pend_q <= pend_n;
         lvl_q  <= lvl_n;
         xisr_q <= xisr_n;
         own_q  <= own_n;
      end
   end

   logic [MSG_W-1:0] msg_d, msg_q;
   assign msg_d = {rej_v_n, rej_num_n, eoi_v_n, eoi_wdata[NUM_W-1:0], rs_n};

   ipc_pulse_reg #(.W(MSG_W), .REG(MSG_REG)) u_msg (
      .clk (clk), .rst_n (rst_n), .d (msg_d), .q (msg_q)
   );

   assign {rej_valid, rej_num, eoi_valid, eoi_num, resend_pulse} = msg_q;
   assign pres_word = {thr_q, xisr_q};
   assign ipi_level = lvl_q;
   assign irq_out   = busy;

   // R2: one response per offer
   p_one_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid |-> (dlv_accept ^ dlv_reject));
   // R2: operations block offers
   p_op_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (dlv_valid && (ack_rd || eoi_wr || thr_wr || ipi_wr)) |-> dlv_reject);
   // R3: taken offer becomes pending
   p_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_accept |=> (pres_word[NUM_W-1:0] == $past(dlv_num)) && irq_out);
   // R4: acknowledge empties the holder
   p_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ack_rd |=> (pres_word[NUM_W-1:0] == '0) && !irq_out);
   // R7: request level stored
   p_lvl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ipi_wr && !ack_rd && !eoi_wr && !thr_wr) |=> (ipi_level == $past(ipi_wdata)));

   generate
      if (MSG_REG) begin : g_msg_chk
         // R3: a reject only names something that was pending
         p_rej_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
            rej_valid |-> ($past(xisr_q) != '0) && (rej_num == $past(xisr_q)));
         // R6: resend only from an empty holder
         p_resend_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
            resend_pulse |-> ($past(xisr_q) == '0));
         // R8: end-of-interrupt forwarded
         p_eoi_fwd_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (eoi_wr && !ack_rd) |=> eoi_valid && (eoi_num == $past(eoi_wdata[NUM_W-1:0])));
      end
   endgenerate
endmodule

// File: tb/sim_intr_present_ctrl.sv
`timescale 1ns/1ps
module sim_intr_present_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        dlv_valid = 0, ack_rd = 0, thr_wr = 0, ipi_wr = 0, eoi_wr = 0;
   logic [23:0] dlv_num = 0;
   logic [7:0]  dlv_prio = 0, thr_wdata = 0, ipi_wdata = 0;
   logic [31:0] eoi_wdata = 0;
   logic        dlv_accept, dlv_reject, irq_out, rej_valid, eoi_valid, resend_pulse;
   logic [31:0] pres_word;
   logic [7:0]  ipi_level;
   logic [23:0] rej_num, eoi_num;

   intr_present_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .dlv_valid(dlv_valid), .dlv_num(dlv_num), .dlv_prio(dlv_prio),
      .dlv_accept(dlv_accept), .dlv_reject(dlv_reject), .ack_rd(ack_rd), .thr_wr(thr_wr),
      .thr_wdata(thr_wdata), .ipi_wr(ipi_wr), .ipi_wdata(ipi_wdata), .eoi_wr(eoi_wr),
      .eoi_wdata(eoi_wdata), .pres_word(pres_word), .ipi_level(ipi_level), .irq_out(irq_out),
      .rej_valid(rej_valid), .rej_num(rej_num), .eoi_valid(eoi_valid), .eoi_num(eoi_num),
      .resend_pulse(resend_pulse)
   );

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // model state
   logic [7:0]  m_thr = 0, m_pend = 8'hFF, m_lvl = 8'hFF;
   logic [23:0] m_xisr = 0;
   bit          m_own = 0;
   bit          e_rej = 0, e_eoi = 0, e_rs = 0;
   logic [23:0] e_rej_n = 0, e_eoi_n = 0;

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit offer_wins(logic [7:0] p);
      return (p < m_thr) && (m_xisr == 0 || p < m_pend);
   endfunction

   task automatic present_ipi();
      m_xisr = 24'd2; m_pend = m_lvl; m_own = 0;
   endtask

   task automatic check_outputs();
      check("R4 R5 pres_word", pres_word, {m_thr, m_xisr});
      check("R7 ipi_level", {24'd0, ipi_level}, {24'd0, m_lvl});
      check("R10 irq_out", {31'd0, irq_out}, {31'd0, (m_xisr != 0)});
      check("R3 rej_valid", {31'd0, rej_valid}, {31'd0, e_rej});
      if (e_rej) check("R3 rej_num", {8'd0, rej_num}, {8'd0, e_rej_n});
      check("R8 eoi_valid", {31'd0, eoi_valid}, {31'd0, e_eoi});
      if (e_eoi) check("R8 eoi_num", {8'd0, eoi_num}, {8'd0, e_eoi_n});
      check("R6 resend_pulse", {31'd0, resend_pulse}, {31'd0, e_rs});
   endtask

   // one cycle: drive at falling edge, check combinational, step model, check after edge
   task automatic step(bit dv, logic [23:0] dn, logic [7:0] dp, bit ak, bit ew, logic [31:0] ed,
                       bit tw, logic [7:0] td, bit iw, logic [7:0] id);
      bit acc, any_op, wasbusy;
      @(negedge clk);
      dlv_valid = dv; dlv_num = dn; dlv_prio = dp; ack_rd = ak; eoi_wr = ew; eoi_wdata = ed;
      thr_wr = tw; thr_wdata = td; ipi_wr = iw; ipi_wdata = id;
      #1;
      any_op = ak || ew || tw || iw;
      acc = dv && !any_op && offer_wins(dp);
      if (dv) begin
         check("R2 dlv_accept", {31'd0, dlv_accept}, {31'd0, acc});
         check("R2 dlv_reject", {31'd0, dlv_reject}, {31'd0, !acc});
      end
      if (ak) check("R4 ack word", pres_word, {m_thr, m_xisr});
      e_rej = 0; e_eoi = 0; e_rs = 0; e_rej_n = m_xisr;
      wasbusy = (m_xisr != 0);
      if (ak) begin                                   // R9 order
         m_thr = m_pend; m_xisr = 0; m_pend = 8'hFF; m_own = 0;
      end else if (ew) begin
         m_thr = ed[31:24]; e_eoi = 1; e_eoi_n = ed[23:0];
         if (!wasbusy) begin
            e_rs = 1;
            if (m_lvl < m_thr) present_ipi();
         end
      end else if (tw) begin
         if (td < m_thr) begin
            m_thr = td;
            if (wasbusy && td <= m_pend) begin
               e_rej = m_own; m_xisr = 0; m_pend = 8'hFF; m_own = 0;
            end
         end else begin
            m_thr = td;
            if (!wasbusy) begin
               e_rs = 1;
               if (m_lvl < m_thr) present_ipi();
            end
         end
      end else if (iw) begin
         m_lvl = id;
         if (id < m_thr && (!wasbusy || id < m_pend)) begin
            e_rej = wasbusy && m_own;
            present_ipi();
         end
      end else if (acc) begin
         e_rej = wasbusy && m_own;
         m_xisr = dn; m_pend = dp; m_own = 1;
      end
      @(posedge clk);
      #2;
      check_outputs();
   endtask

   task automatic offer(logic [23:0] n, logic [7:0] p);
      step(1, n, p, 0, 0, 0, 0, 0, 0, 0);
   endtask

   function automatic logic [7:0] rprio();
      int v = $urandom % 10;
      return (v == 9) ? 8'hFF : 8'(v);
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      #1;
      // R1 reset state
      check("R1 pres_word", pres_word, 32'd0);
      check("R1 ipi_level", {24'd0, ipi_level}, 32'hFF);
      check("R1 irq_out", {31'd0, irq_out}, 0);
      check("R1 pulses", {29'd0, rej_valid, eoi_valid, resend_pulse}, 0);
      // R2 threshold 0 rejects everything
      offer(24'h40, 8'h00);
      // R6 raise threshold with nothing pending: resend, no inter-processor since level FF
      step(0, 0, 0, 0, 0, 0, 1, 8'hFF, 0, 0);
      offer(24'h41, 8'h05);                 // R3 taken
      offer(24'h42, 8'h05);                 // R2 equal priority bounced
      offer(24'h43, 8'h03);                 // R3 displaces, reject of 0x41
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h01); // R7 inter-processor, reject of 0x43
      offer(24'h44, 8'h00);                 // R3 displaces inter-processor, no reject
      step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0);   // R4 acknowledge
      step(0, 0, 0, 0, 1, 32'hFF00_0044, 0, 0, 0, 0); // R8 eoi, resend, inter-processor
      step(0, 0, 0, 0, 0, 0, 1, 8'h01, 0, 0); // R5 clear pending inter-processor
      step(0, 0, 0, 0, 0, 0, 1, 8'h08, 0, 0); // R6 resend with inter-processor
      step(1, 24'h45, 8'h00, 1, 1, 32'h0700_0011, 1, 8'h02, 1, 8'h03); // R9 all at once
      // random traffic
      for (int i = 0; i < 4000; i++) begin
         int k = $urandom % 16;
         bit dv = ($urandom % 2) == 1;
         logic [23:0] dn = 24'h10 + 24'($urandom % 64);
         step(dv, dn, rprio(),
              k == 0, k == 1 || k == 6, {rprio(), 8'h00, 16'($urandom)},
              k == 2 || k == 3 || k == 6, rprio(), k == 4 || k == 5 || k == 6, rprio());
      end
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL R1 watchdog actual=hung expected=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule